// File: doc/BRIEF.md
# DMA Translation Unit Control and Fault Registers

This block is the software-visible register file of a DMA address-translation unit. A host reaches it through a word-indexed, 32-bit read/write port. Each register applies its own write mask and its own forced-one bits. Writing the control register sets the translation enable. It also decodes a three-bit size code into the lowest address of the translation window, and that address is held until the next control write. The page-table base is presented to the translation engine, together with the enable and the window start.

The translation engine reports a failed lookup with a one-cycle capture pulse. The pulse carries the faulting address and whether the access was a read. The block records a fixed error syndrome and the page address of the fault, and then raises a level interrupt. Software lowers the interrupt by touching either fault register, with a read or a write. Read data is a combinational view of the register selected by the index. Only a cycle with the access strobe high has side effects.

Top module: `dxc_csr`

## Requirements
- R1: After reset the registers read as follows: control `{VERSION,24'h0}`; arbitration-enable (index 0x800) 0x00000008; fault status (index 0x400) 0x00800000; arbiter-enable (index 0x402) 0x00000003; mask-ID (index 0xC06) 0x23000000. Every other register reads 0. The window start, the enable and the interrupt are 0.
- R2: A write to control (index 0x000) stores the data ANDed with 0x0000001D, with `VERSION` in bits [31:24]. `xl_enable` then follows stored bit 0.
- R3: A control write loads `win_start` from data bits [4:2]. Code k gives 0xFF000000 shifted left by k bits, so code 0 gives 0xFF000000 and code 7 gives 0x80000000. At all other times `win_start` holds its value.
- R4: The base register (index 0x001) keeps only the data bits under 0x07FFFC00, and `tbl_base` presents its value.
- R5: The two flush registers (indices 0x005 and 0x006) store the write data in full.
- R6: Each slot-config register (indices 0x404 to 0x404+N_SLOTS-1) keeps only the data bits under 0x00010003. A write to one slot leaves the other slots unchanged.
- R7: The arbiter-enable register stores (data AND 0x801F000F) OR 0x1. The arbitration-enable register stores (data AND 0x001F0000) OR 0x8.
- R8: A fault-status write stores (data AND 0xFF0FFFFF) OR 0x00800000. A fault-address write (index 0x401) stores the data in full.
- R9: A mask-ID write ORs (data AND 0x00FFFFFF) into the current contents. It never clears a bit.
- R10: A fault-capture pulse sets fault status to 0xC0820000, or to 0xC0860000 when the access was a read (bit 18). It loads the fault address with the faulting address with the low PAGE_SHIFT bits cleared, and it raises `irq` on the next cycle.
- R11: An access (read or write) to fault status or fault address with no capture pulse in the same cycle lowers `irq`. A read index presented with the strobe low does not lower `irq`.
- R12: When a capture pulse and a software access to the fault registers fall in the same cycle, the capture values are stored and `irq` stays high.
- R13: An index with no register reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_widx | input | ADDR_W | Word index of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_widx` (combinational) |
| flt_pulse | input | 1 | Fault-capture pulse from the translation engine |
| flt_addr | input | 32 | Faulting address |
| flt_is_read | input | 1 | Faulting access was a read |
| xl_enable | output | 1 | Translation enable |
| win_start | output | 32 | Lowest address of the translation window |
| tbl_base | output | 32 | Page-table base register value |
| irq | output | 1 | Level fault interrupt |

## Verification
The bound checker watches the interrupt protocol on every cycle. It checks that a capture pulse raises `irq`, that `irq` rises only after a capture, and that a fault-register access with no capture lowers it. On every cycle it also checks that the enable follows the control write, that the window start changes only on a control write, and that the base output never carries bits outside its mask. The mask and forced-bit values of each register can only be shown by the bench's directed writes and read-backs. The same holds for the full table of window codes, the OR-only mask-ID update, the isolation between slots, silent unmapped indices and the same-cycle race between capture and software access.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
   // word indices (byte offset / 4)
   localparam int unsigned IDX_CTRL   = 32'h000;
   localparam int unsigned IDX_BASE   = 32'h001;
   localparam int unsigned IDX_TFLUSH = 32'h005;
   localparam int unsigned IDX_PFLUSH = 32'h006;
   localparam int unsigned IDX_FSTAT  = 32'h400;
   localparam int unsigned IDX_FADDR  = 32'h401;
   localparam int unsigned IDX_ARBMSK = 32'h402;
   localparam int unsigned IDX_SLOT0  = 32'h404;
   localparam int unsigned IDX_ARBEN  = 32'h800;
   localparam int unsigned IDX_MID    = 32'hC06;
   localparam int unsigned MIN_ADDR_W = 12;
   localparam int unsigned MAX_SLOTS  = 4;

   // keep masks and forced bits
   localparam logic [31:0] CTRL_KEEP   = 32'h0000_001D;
   localparam logic [31:0] BASE_KEEP   = 32'h07FF_FC00;
   localparam logic [31:0] SLOT_KEEP   = 32'h0001_0003;
   localparam logic [31:0] ARBMSK_KEEP = 32'h801F_000F;
   localparam logic [31:0] ARBMSK_SET  = 32'h0000_0001;
   localparam logic [31:0] ARBEN_KEEP  = 32'h001F_0000;
   localparam logic [31:0] ARBEN_SET   = 32'h0000_0008;
   localparam logic [31:0] FSTAT_KEEP  = 32'h FF0F_FFFF;
   localparam logic [31:0] FSTAT_SET   = 32'h0080_0000;
   localparam logic [31:0] MID_KEEP    = 32'h00FF_FFFF;

   // reset values
   localparam logic [31:0] ARBMSK_RST  = 32'h0000_0003;
   localparam logic [31:0] MID_RST     = 32'h2300_0000;

   // fault syndrome bits
   localparam logic [31:0] FS_ERR = 32'h8000_0000;
   localparam logic [31:0] FS_LE  = 32'h4000_0000;
   localparam logic [31:0] FS_RD  = 32'h0004_0000;
   localparam logic [31:0] FS_FAV = 32'h0002_0000;

   // window code field of the control word
   localparam int unsigned WIN_LSB = 2;
   localparam int unsigned WIN_W   = 3;
   typedef logic [WIN_W-1:0] win_code_t;
endpackage

// File: rtl/dxc_window_dec.sv
module dxc_window_dec
   import dxc_pkg::*;
#(
   parameter int unsigned MIN_WIN_LOG2 = 24
) (
   input  win_code_t   code,
   output logic [31:0] start
);
   localparam logic [31:0] ONE = 32'h1;

   if (MIN_WIN_LOG2 + (1 << WIN_W) - 1 > 31) begin : g_bad_win
      $error("dxc_window_dec: window range exceeds 32-bit space");
   end

   // window of 2^(MIN_WIN_LOG2+code) bytes ending at the top of the space
   always_comb begin
      logic [31:0] size;
      size  = ONE << (MIN_WIN_LOG2 + 32'(code));
      start = ~(size - ONE);
   end
endmodule

// File: rtl/dxc_fault_unit.sv
module dxc_fault_unit
   import dxc_pkg::*;
#(
   parameter int unsigned PAGE_SHIFT = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sw_wr_stat,
   input  logic        sw_wr_addr,
   input  logic        sw_touch,
   input  logic [31:0] sw_wdata,
   input  logic        cap,
   input  logic [31:0] cap_addr,
   input  logic        cap_rd,
   output logic [31:0] stat_q,
   output logic [31:0] addr_q,
   output logic        irq_q
);
   localparam logic [31:0] PAGE_MASK = ~((32'h1 << PAGE_SHIFT) - 32'h1);
   localparam logic [31:0] CAP_BASE  = FS_ERR | FS_LE | FSTAT_SET | FS_FAV;

   if (PAGE_SHIFT < 1 || PAGE_SHIFT > 31) begin : g_bad_page
      $error("dxc_fault_unit: PAGE_SHIFT out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= FSTAT_SET;
         addr_q <= '0;
         irq_q  <= 1'b0;
      end else if (cap) begin
         // capture has priority over any software access
         stat_q <= CAP_BASE | (cap_rd ? FS_RD : 32'h0);
         addr_q <= cap_addr & PAGE_MASK;
         irq_q  <= 1'b1;
      end else begin
         if (sw_wr_stat) stat_q <= (sw_wdata & FSTAT_KEEP) | FSTAT_SET;
         if (sw_wr_addr) addr_q <= sw_wdata;
         if (sw_touch)   irq_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/dxc_slot_bank.sv
module dxc_slot_bank
   import dxc_pkg::*;
#(
   parameter int unsigned N_SLOTS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SLOTS-1:0] wr_sel,
   input  logic [31:0]        wdata,
   output logic [31:0]        cfg_q [N_SLOTS]
);
   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)         cfg_q[s] <= '0;
         else if (wr_sel[s]) cfg_q[s] <= wdata & SLOT_KEEP;
      end
   end
endmodule

// File: rtl/dxc_csr.sv
module dxc_csr
   import dxc_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned N_SLOTS      = 4,
   parameter logic [7:0]  VERSION      = 8'h41,
   parameter int unsigned PAGE_SHIFT   = 12,
   parameter int unsigned MIN_WIN_LOG2 = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [ADDR_W-1:0] acc_widx,
   input  logic [31:0]       acc_wdata,
   output logic [31:0]       acc_rdata,
   input  logic              flt_pulse,
   input  logic [31:0]       flt_addr,
   input  logic              flt_is_read,
   output logic              xl_enable,
   output logic [31:0]       win_start,
   output logic [31:0]       tbl_base,
   output logic              irq
);
   localparam logic [31:0] VER_WORD = {VERSION, 24'h0};

   if (ADDR_W < MIN_ADDR_W || ADDR_W > 31) begin : g_bad_aw
      $error("dxc_csr: ADDR_W must cover the register map");
   end
   if (N_SLOTS < 1 || N_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("dxc_csr: N_SLOTS out of range");
   end

   logic [31:0] widx;
   assign widx = 32'(acc_widx);

   logic wr, touch_fault;
   assign wr = acc_en && acc_we;
   assign touch_fault = acc_en && (widx == IDX_FSTAT || widx == IDX_FADDR);

   logic        hit_slot;
   logic [31:0] slot_off;
   assign slot_off = widx - IDX_SLOT0;
   assign hit_slot = (widx >= IDX_SLOT0) && (slot_off < N_SLOTS);

   // simple registers
   logic [31:0] ctrl_q, base_q, tfl_q, pfl_q, arbmsk_q, arben_q, mid_q, win_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= VER_WORD;
         base_q   <= '0;
         tfl_q    <= '0;
         pfl_q    <= '0;
         arbmsk_q <= ARBMSK_RST;
         arben_q  <= ARBEN_SET;
         mid_q    <= MID_RST;
      end else if (wr) begin
         if (widx == IDX_CTRL)   ctrl_q   <= (acc_wdata & CTRL_KEEP) | VER_WORD;
         if (widx == IDX_BASE)   base_q   <= acc_wdata & BASE_KEEP;
         if (widx == IDX_TFLUSH) tfl_q    <= acc_wdata;
         if (widx == IDX_PFLUSH) pfl_q    <= acc_wdata;
         if (widx == IDX_ARBMSK) arbmsk_q <= (acc_wdata & ARBMSK_KEEP) | ARBMSK_SET;
         if (widx == IDX_ARBEN)  arben_q  <= (acc_wdata & ARBEN_KEEP) | ARBEN_SET;
         if (widx == IDX_MID)    mid_q    <= mid_q | (acc_wdata & MID_KEEP);
      end
   end

   // window start, loaded only on control write
   logic [31:0] win_dec;
   dxc_window_dec #(.MIN_WIN_LOG2(MIN_WIN_LOG2)) u_win (
      .code  (acc_wdata[WIN_LSB +: WIN_W]),
      .start (win_dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                       win_q <= '0;
      else if (wr && widx == IDX_CTRL)  win_q <= win_dec;
   end

   // per-slot configuration
   logic [N_SLOTS-1:0] slot_wr;
   logic [31:0]        slot_q [N_SLOTS];
   for (genvar s = 0; s < N_SLOTS; s++) begin : g_swr
      assign slot_wr[s] = wr && (widx == IDX_SLOT0 + s);
   end

   dxc_slot_bank #(.N_SLOTS(N_SLOTS)) u_slots (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (slot_wr),
      .wdata  (acc_wdata),
      .cfg_q  (slot_q)
   );

   // fault capture and interrupt
   logic [31:0] fstat_q, faddr_q;
   logic        irq_q;
   dxc_fault_unit #(.PAGE_SHIFT(PAGE_SHIFT)) u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_wr_stat (wr && widx == IDX_FSTAT),
      .sw_wr_addr (wr && widx == IDX_FADDR),
      .sw_touch   (touch_fault),
      .sw_wdata   (acc_wdata),
      .cap        (flt_pulse),
      .cap_addr   (flt_addr),
      .cap_rd     (flt_is_read),
      .stat_q     (fstat_q),
      .addr_q     (faddr_q),
      .irq_q      (irq_q)
   );

   // read mux
   always_comb begin
      acc_rdata = '0;
      if (hit_slot) begin
         for (int s = 0; s < N_SLOTS; s++)
            if (slot_off == s) acc_rdata = slot_q[s];
      end else begin
         case (widx)
            IDX_CTRL:   acc_rdata = ctrl_q;
            IDX_BASE:   acc_rdata = base_q;
            IDX_TFLUSH: acc_rdata = tfl_q;
            IDX_PFLUSH: acc_rdata = pfl_q;
            IDX_FSTAT:  acc_rdata = fstat_q;
            IDX_FADDR:  acc_rdata = faddr_q;
            IDX_ARBMSK: acc_rdata = arbmsk_q;
            IDX_ARBEN:  acc_rdata = arben_q;
            IDX_MID:    acc_rdata = mid_q;
            default:    acc_rdata = '0;
         endcase
      end
   end

   assign xl_enable = ctrl_q[0];
   assign win_start = win_q;
   assign tbl_base  = base_q;
   assign irq       = irq_q;
endmodule

// File: rtl/dxc_csr_chk.sv
module dxc_csr_chk
   import dxc_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_we,
   input logic [ADDR_W-1:0] acc_widx,
   input logic [31:0]       acc_wdata,
   input logic              flt_pulse,
   input logic              xl_enable,
   input logic [31:0]       win_start,
   input logic [31:0]       tbl_base,
   input logic              irq
);
   logic ctrl_wr, fault_touch;
   assign ctrl_wr     = acc_en && acc_we && (32'(acc_widx) == IDX_CTRL);
   assign fault_touch = acc_en && (32'(acc_widx) == IDX_FSTAT ||
                                   32'(acc_widx) == IDX_FADDR);

   assert_enable_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> xl_enable == $past(acc_wdata[0]));

   assert_window_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(win_start));

   assert_base_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_base & ~BASE_KEEP) == 32'h0);

   assert_irq_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flt_pulse |=> irq);

   assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(flt_pulse));

   assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_touch && !flt_pulse) |=> !irq);
endmodule

bind dxc_csr dxc_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_en    (acc_en),
   .acc_we    (acc_we),
   .acc_widx  (acc_widx),
   .acc_wdata (acc_wdata),
   .flt_pulse (flt_pulse),
   .xl_enable (xl_enable),
   .win_start (win_start),
   .tbl_base  (tbl_base),
   .irq       (irq)
);

// File: tb/tb_dxc_csr.sv
module tb_dxc_csr;
   localparam logic [7:0] VER = 8'h41;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_we = 1'b0;
   logic [11:0] acc_widx = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        flt_pulse = 1'b0, flt_is_read = 1'b0;
   logic [31:0] flt_addr = '0;
   logic        xl_enable, irq;
   logic [31:0] win_start, tbl_base;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dxc_csr #(.VERSION(VER)) dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
      .acc_widx(acc_widx), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .flt_pulse(flt_pulse), .flt_addr(flt_addr), .flt_is_read(flt_is_read),
      .xl_enable(xl_enable), .win_start(win_start), .tbl_base(tbl_base),
      .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // one-cycle access, inputs changed at negedge
   task automatic access(input logic we, input logic [11:0] idx, input logic [31:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_we = we; acc_widx = idx; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0;
   endtask

   task automatic wr(input logic [11:0] idx, input logic [31:0] d);
      access(1'b1, idx, d);
   endtask

   // look at a register without an access strobe
   task automatic peek(input logic [11:0] idx, output logic [31:0] d);
      acc_widx = idx;
      #1 d = acc_rdata;
   endtask

   task automatic fault(input logic [31:0] a, input logic rd);
      @(negedge clk);
      flt_pulse = 1'b1; flt_addr = a; flt_is_read = rd;
      @(negedge clk);
      flt_pulse = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      peek(12'h000, v); chk("R1 ctrl", v, {VER, 24'h0});
      peek(12'h800, v); chk("R1 arben", v, 32'h8);
      peek(12'h400, v); chk("R1 fstat", v, 32'h0080_0000);
      peek(12'h402, v); chk("R1 arbmsk", v, 32'h3);
      peek(12'hC06, v); chk("R1 mid", v, 32'h2300_0000);
      peek(12'h001, v); chk("R1 base", v, 32'h0);
      peek(12'h401, v); chk("R1 faddr", v, 32'h0);
      chk("R1 win", win_start, 32'h0);
      chk("R1 en", {31'h0, xl_enable}, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_ctrl;
      logic [31:0] v;
      wr(12'h000, 32'hFFFF_FFFF);
      peek(12'h000, v); chk("R2 ctrl all ones", v, {VER, 24'h1D});
      chk("R2 enable on", {31'h0, xl_enable}, 32'h1);
      for (int k = 0; k < 8; k++) begin
         wr(12'h000, 32'(k) << 2);
         chk("R3 window code", win_start, 32'hFF00_0000 << k);
         chk("R2 enable off", {31'h0, xl_enable}, 32'h0);
      end
      wr(12'h003, 32'h0000_0010);
      chk("R3 window held", win_start, 32'h8000_0000);
   endtask

   task automatic t_masks;
      logic [31:0] v;
      wr(12'h001, 32'hFFFF_FFFF);
      peek(12'h001, v); chk("R4 base", v, 32'h07FF_FC00);
      chk("R4 tbl_base", tbl_base, 32'h07FF_FC00);
      wr(12'h005, 32'hDEAD_BEEF);
      peek(12'h005, v); chk("R5 tlb flush", v, 32'hDEAD_BEEF);
      wr(12'h006, 32'h1234_5678);
      peek(12'h006, v); chk("R5 page flush", v, 32'h1234_5678);
      for (int s = 0; s < 4; s++) wr(12'(12'h404 + s), 32'hFFFF_FFFF);
      wr(12'h405, 32'h0);
      for (int s = 0; s < 4; s++) begin
         peek(12'(12'h404 + s), v);
         chk("R6 slot", v, (s == 1) ? 32'h0 : 32'h0001_0003);
      end
      wr(12'h402, 32'h0);
      peek(12'h402, v); chk("R7 arbmsk forced", v, 32'h1);
      wr(12'h402, 32'hFFFF_FFFF);
      peek(12'h402, v); chk("R7 arbmsk mask", v, 32'h801F_000F);
      wr(12'h800, 32'h0);
      peek(12'h800, v); chk("R7 arben forced", v, 32'h8);
      wr(12'h800, 32'hFFFF_FFFF);
      peek(12'h800, v); chk("R7 arben mask", v, 32'h001F_0008);
      wr(12'h400, 32'h0);
      peek(12'h400, v); chk("R8 fstat forced", v, 32'h0080_0000);
      wr(12'h400, 32'hFFFF_FFFF);
      peek(12'h400, v); chk("R8 fstat mask", v, 32'hFF8F_FFFF);
      wr(12'h401, 32'hCAFE_F00D);
      peek(12'h401, v); chk("R8 faddr", v, 32'hCAFE_F00D);
      wr(12'hC06, 32'h0000_00F0);
      peek(12'hC06, v); chk("R9 mid or", v, 32'h2300_00F0);
      wr(12'hC06, 32'hFF00_000F);
      peek(12'hC06, v); chk("R9 mid keep", v, 32'h2300_00FF);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      wr(12'h003, 32'hFFFF_FFFF);
      peek(12'h003, v); chk("R13 unmapped 003", v, 32'h0);
      wr(12'h7FF, 32'hFFFF_FFFF);
      peek(12'h7FF, v); chk("R13 unmapped 7FF", v, 32'h0);
      peek(12'h001, v); chk("R13 base untouched", v, 32'h07FF_FC00);
   endtask

   task automatic t_fault;
      logic [31:0] v;
      fault(32'h1234_5678, 1'b1);
      chk("R10 irq set", {31'h0, irq}, 32'h1);
      peek(12'h400, v); chk("R10 stat read", v, 32'hC086_0000);
      peek(12'h401, v); chk("R10 addr page", v, 32'h1234_5000);
      @(negedge clk);
      chk("R11 peek keeps irq", {31'h0, irq}, 32'h1);
      access(1'b0, 12'h400, 32'h0);
      chk("R11 read clears irq", {31'h0, irq}, 32'h0);
      fault(32'h0000_1FFF, 1'b0);
      peek(12'h400, v); chk("R10 stat write", v, 32'hC082_0000);
      wr(12'h401, 32'h0000_AAAA);
      chk("R11 write clears irq", {31'h0, irq}, 32'h0);
      peek(12'h401, v); chk("R8 faddr after", v, 32'h0000_AAAA);
   endtask

   task automatic t_race;
      logic [31:0] v;
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b1; acc_widx = 12'h400; acc_wdata = 32'h0;
      flt_pulse = 1'b1; flt_addr = 32'h8765_4321; flt_is_read = 1'b1;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0; flt_pulse = 1'b0;
      chk("R12 irq held", {31'h0, irq}, 32'h1);
      peek(12'h400, v); chk("R12 stat capture", v, 32'hC086_0000);
      peek(12'h401, v); chk("R12 addr capture", v, 32'h8765_4000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_masks();
      t_unmapped();
      t_fault();
      t_race();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule